// File: doc/BRIEF.md
# CAN transceiver mode controller

This block is the digital control side of a high-speed CAN transceiver. It tracks one of four operating modes from a supply-undervoltage flag, a sleep request, a transmit-enable input, the transmit bit from the protocol controller and an internal error flag. The bus arrives already sampled as one dominant/recessive bit. The block decides whether the transmit bit may reach the line driver, and what the receive pin shows.

In the active mode the receive pin mirrors the bus and the transmitter follows the transmit bit. In listen-only mode the transmitter is held recessive while the receive pin still mirrors the bus. In the low-power sleep mode the transmitter is off and the receive pin carries a wake indication. That indication is raised only by a dominant pulse long enough to pass a filter. A second, longer limit releases it, so that a bus stuck dominant cannot hold the indication for ever. Entry into the active mode is guarded: the transmit bit must be recessive and no error may be pending, so the block cannot start driving a dominant bit on the bus.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: After reset `mode_o` reads 0, and it stays 0 while `vcc_low_i` is high. The mode codes are: 0 off, 1 sleep, 2 listen-only, 3 active.
- R2: In any mode, `vcc_low_i` high at a clock edge sets the mode to 0 at that edge. This takes priority over every other input.
- R3: In mode 0 with `vcc_low_i` low, the mode becomes 1 at the next edge.
- R4: In mode 1, the mode becomes 3 only when `sleep_req_i`=0, `tx_enable_i`=1, `tx_bit_i`=1 (recessive) and `err_i`=0. If `tx_enable_i` is 1 but `tx_bit_i` is 0 or `err_i` is 1, the mode stays 1.
- R5: In mode 3 with `sleep_req_i`=0, `tx_enable_i`=0 or `err_i`=1 moves the mode to 2.
- R6: In mode 2 with `sleep_req_i`=0, the mode returns to 3 only when `tx_enable_i`=1, `tx_bit_i`=1 and `err_i`=0. Otherwise it stays 2.
- R7: In mode 2 or 3, `sleep_req_i`=1 moves the mode to 1, even when an error is pending.
- R8: In mode 1, `sleep_req_i`=0 together with `tx_enable_i`=0 moves the mode to 2.
- R9: `tx_dom_o` is 1 only in mode 3 while `tx_bit_i` is 0. In modes 0, 1 and 2 it is 0 whatever `tx_bit_i` is.
- R10: In modes 2 and 3, `rx_bit_o` is the inverse of `bus_dom_i` (0 while dominant). In mode 0, `rx_bit_o` is 1.
- R11: In mode 1, a run of fewer than WAKE_CYC consecutive dominant samples leaves `rx_bit_o` at 1. The WAKE_CYC-th consecutive sample drives `rx_bit_o` to 0 from that edge on. It then stays 0 after the bus returns recessive, until the block leaves mode 1.
- R12: In mode 1, the TOUT_CYC-th consecutive dominant sample (TOUT_CYC > WAKE_CYC) returns `rx_bit_o` to 1. It stays 1 while the bus remains dominant. A new wake needs a recessive sample followed by a fresh run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vcc_low_i | input | 1 | Supply below the undervoltage threshold |
| sleep_req_i | input | 1 | 1 requests the low-power sleep mode |
| tx_enable_i | input | 1 | 1 permits transmission, 0 requests listen-only |
| tx_bit_i | input | 1 | Transmit bit from the protocol controller, 0 = dominant |
| err_i | input | 1 | Internal error flag |
| bus_dom_i | input | 1 | Sampled bus state, 1 = dominant |
| mode_o | output | 2 | Current mode: 0 off, 1 sleep, 2 listen-only, 3 active |
| tx_dom_o | output | 1 | Line driver command, 1 = drive dominant |
| rx_bit_o | output | 1 | Receive pin, 0 = dominant or wake indication |

## Verification
The properties assume that the control inputs and the bus bit are already synchronous to `clk`. They also assume that `bus_dom_i` is a clean per-cycle sample, so each high cycle counts as one dominant sample. The stimulus changes every input only at the falling edge and holds it across the next rising edge. Dominant runs are built from whole cycles, so run lengths of exactly WAKE_CYC−1, WAKE_CYC and TOUT_CYC are reached without any ambiguity.

// File: rtl/can_xcvr_pkg.sv
package can_xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_SLEEP  = 2'd1,
    MODE_LISTEN = 2'd2,
    MODE_ACTIVE = 2'd3
  } xcvr_mode_e;
endpackage

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_low,
  input  logic       sleep_req,
  input  logic       tx_enable,
  input  logic       tx_bit,
  input  logic       err,
  output xcvr_mode_e mode
);
  xcvr_mode_e mode_q, mode_d;
  logic       go_active;

  // guarded entry: transmitter recessive and no error pending
  assign go_active = tx_enable & tx_bit & ~err;

  always_comb begin
    mode_d = mode_q;
    if (vcc_low) begin
      mode_d = MODE_OFF;
    end else begin
      unique case (mode_q)
        MODE_OFF:    mode_d = MODE_SLEEP;
        MODE_SLEEP: begin
          if (!sleep_req) begin
            if (go_active)       mode_d = MODE_ACTIVE;
            else if (!tx_enable) mode_d = MODE_LISTEN;
          end
        end
        MODE_LISTEN: begin
          if (sleep_req)      mode_d = MODE_SLEEP;
          else if (go_active) mode_d = MODE_ACTIVE;
        end
        MODE_ACTIVE: begin
          if (sleep_req)               mode_d = MODE_SLEEP;
          else if (!tx_enable || err)  mode_d = MODE_LISTEN;
        end
        default: mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/can_wake_filter.sv
module can_wake_filter #(
  parameter int WAKE_CYC = 8,
  parameter int TOUT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_sleep,
  input  logic bus_dom,
  output logic wake
);
  localparam int CNT_W = $clog2(TOUT_CYC + 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] TOUT_LAST = CNT_W'(TOUT_CYC - 1);
  localparam logic [CNT_W-1:0] TOUT_MAX  = CNT_W'(TOUT_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             run, cnt_en;

  assign run    = in_sleep & bus_dom;
  assign cnt_en = run & (cnt_q != TOUT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb begin
    flag_d = flag_q;
    if (!in_sleep)                        flag_d = 1'b0;
    else if (bus_dom && cnt_q == TOUT_LAST) flag_d = 1'b0;
    else if (bus_dom && cnt_q == WAKE_LAST) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign wake = flag_q;
endmodule

// File: rtl/can_path_mux.sv
module can_path_mux
  import can_xcvr_pkg::*;
(
  input  xcvr_mode_e mode,
  input  logic       tx_bit,
  input  logic       bus_dom,
  input  logic       wake,
  output logic       tx_dom,
  output logic       rx_bit
);
  always_comb begin
    tx_dom = 1'b0;
    rx_bit = 1'b1;
    unique case (mode)
      MODE_ACTIVE: begin
        tx_dom = ~tx_bit;
        rx_bit = ~bus_dom;
      end
      MODE_LISTEN: rx_bit = ~bus_dom;
      MODE_SLEEP:  rx_bit = ~wake;
      default:     rx_bit = 1'b1;
    endcase
  end
endmodule

// File: rtl/can_xcvr_mode_ctrl.sv
module can_xcvr_mode_ctrl
  import can_xcvr_pkg::*;
#(
  parameter int WAKE_CYC = 8,
  parameter int TOUT_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_low_i,
  input  logic       sleep_req_i,
  input  logic       tx_enable_i,
  input  logic       tx_bit_i,
  input  logic       err_i,
  input  logic       bus_dom_i,
  output logic [1:0] mode_o,
  output logic       tx_dom_o,
  output logic       rx_bit_o
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  xcvr_mode_e mode;
  logic       wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  can_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sn),
    .vcc_low   (vcc_low_i),
    .sleep_req (sleep_req_i),
    .tx_enable (tx_enable_i),
    .tx_bit    (tx_bit_i),
    .err       (err_i),
    .mode      (mode)
  );

  can_wake_filter #(.WAKE_CYC(WAKE_CYC), .TOUT_CYC(TOUT_CYC)) u_wake (
    .clk      (clk),
    .rst_n    (rst_sn),
    .in_sleep (mode == MODE_SLEEP),
    .bus_dom  (bus_dom_i),
    .wake     (wake)
  );

  can_path_mux u_mux (
    .mode    (mode),
    .tx_bit  (tx_bit_i),
    .bus_dom (bus_dom_i),
    .wake    (wake),
    .tx_dom  (tx_dom_o),
    .rx_bit  (rx_bit_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/can_xcvr_mode_chk.sv
module can_xcvr_mode_chk #(
  parameter int TOUT_CYC = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_low,
  input logic       sleep_req,
  input logic       tx_enable,
  input logic       tx_bit,
  input logic       err,
  input logic       bus_dom,
  input logic [1:0] mode,
  input logic       tx_dom,
  input logic       rx_bit
);
  localparam int RUN_W = $clog2(TOUT_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TOUT_CYC);

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              run_q <= '0;
    else if (!(mode == 2'd1 && bus_dom))     run_q <= '0;
    else if (run_q != RUN_MAX)               run_q <= run_q + RUN_W'(1);
  end

  // R2
  uv_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low |=> mode == 2'd0);

  // R3
  power_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !vcc_low) |=> mode == 2'd1);

  // R4
  guarded_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !(!sleep_req && tx_enable && tx_bit && !err)) |=> mode != 2'd3);

  // R5
  active_to_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !vcc_low && !sleep_req && (!tx_enable || err)) |=> mode == 2'd2);

  // R7
  sleep_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !vcc_low && sleep_req) |=> mode == 2'd1);

  // R9
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3) |-> !tx_dom);

  // R10
  off_rx_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> rx_bit);

  // R12
  clamp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && run_q == RUN_MAX) |-> rx_bit);
endmodule

bind can_xcvr_mode_ctrl can_xcvr_mode_chk #(.TOUT_CYC(TOUT_CYC)) i_mode_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .vcc_low   (vcc_low_i),
  .sleep_req (sleep_req_i),
  .tx_enable (tx_enable_i),
  .tx_bit    (tx_bit_i),
  .err       (err_i),
  .bus_dom   (bus_dom_i),
  .mode      (mode_o),
  .tx_dom    (tx_dom_o),
  .rx_bit    (rx_bit_o)
);

// File: tb/test_can_xcvr_mode_ctrl.sv
`timescale 1ns/1ps
module test_can_xcvr_mode_ctrl;
  localparam int WAKE = 4;
  localparam int TOUT = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic vcc_low, sleep_req, tx_en, tx_bit, err, bus;
  logic [1:0] mode;
  logic tx_dom, rx_bit;

  int checks = 0;
  int errors = 0;

  logic [1:0] q_mode[$];
  logic       q_tx[$];
  logic       q_rx[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  can_xcvr_mode_ctrl #(.WAKE_CYC(WAKE), .TOUT_CYC(TOUT)) i_can_xcvr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .sleep_req_i(sleep_req),
    .tx_enable_i(tx_en), .tx_bit_i(tx_bit), .err_i(err), .bus_dom_i(bus),
    .mode_o(mode), .tx_dom_o(tx_dom), .rx_bit_o(rx_bit)
  );

  // driver: apply inputs at the falling edge, expect results after the next rise
  task automatic step(input logic sl, st, en, tb, er, bu,
                      input logic [1:0] em, input logic et, input logic erx,
                      input string tag);
    @(negedge clk);
    vcc_low = sl; sleep_req = st; tx_en = en; tx_bit = tb; err = er; bus = bu;
    q_mode.push_back(em); q_tx.push_back(et); q_rx.push_back(erx); q_tag.push_back(tag);
  endtask

  task automatic repeat_step(input int n, input logic bu, input logic erx, input string tag);
    for (int i = 0; i < n; i++) step(0, 1, 1, 1, 0, bu, 2'd1, 0, erx, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_mode.size() > 0) begin
        logic [1:0] em;
        logic et, erx;
        string tg;
        em = q_mode.pop_front(); et = q_tx.pop_front();
        erx = q_rx.pop_front(); tg = q_tag.pop_front();
        checks++;
        if (mode !== em || tx_dom !== et || rx_bit !== erx) begin
          errors++;
          $display("FAIL %s: mode=%0d tx=%b rx=%b expected mode=%0d tx=%b rx=%b",
                   tg, mode, tx_dom, rx_bit, em, et, erx);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    vcc_low = 1; sleep_req = 1; tx_en = 1; tx_bit = 1; err = 0; bus = 0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (mode !== 2'd0 || tx_dom !== 1'b0 || rx_bit !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: mode=%0d tx=%b rx=%b expected mode=0 tx=0 rx=1", mode, tx_dom, rx_bit);
    end
    @(negedge clk);
    rst_n = 1'b1;

    repeat (3) step(1, 1, 1, 1, 0, 0, 2'd0, 0, 1, "R1");
    step(1, 1, 1, 0, 0, 1, 2'd0, 0, 1, "R10");
    step(0, 1, 1, 1, 0, 0, 2'd1, 0, 1, "R3");
    step(0, 1, 1, 0, 0, 0, 2'd1, 0, 1, "R9");
    step(0, 0, 1, 0, 0, 0, 2'd1, 0, 1, "R4");
    step(0, 0, 1, 1, 1, 0, 2'd1, 0, 1, "R4");
    step(0, 0, 1, 1, 0, 0, 2'd3, 0, 1, "R4");
    step(0, 0, 1, 0, 0, 1, 2'd3, 1, 0, "R10");
    step(0, 0, 1, 1, 0, 0, 2'd3, 0, 1, "R10");
    step(0, 0, 0, 0, 0, 1, 2'd2, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 1, 2'd2, 0, 0, "R9");
    step(0, 0, 1, 1, 0, 0, 2'd3, 0, 1, "R6");
    step(0, 0, 1, 1, 1, 0, 2'd2, 0, 1, "R5");
    step(0, 1, 1, 1, 1, 0, 2'd1, 0, 1, "R7");
    step(0, 0, 1, 1, 0, 0, 2'd3, 0, 1, "R4");
    step(0, 1, 1, 1, 0, 0, 2'd1, 0, 1, "R7");

    repeat_step(WAKE - 1, 1, 1, "R11");
    repeat_step(1, 0, 1, "R11");
    repeat_step(WAKE - 1, 1, 1, "R11");
    repeat_step(1, 1, 0, "R11");
    repeat_step(3, 0, 0, "R11");
    step(0, 0, 0, 1, 0, 0, 2'd2, 0, 1, "R8");
    repeat_step(1, 0, 1, "R11");

    repeat_step(WAKE - 1, 1, 1, "R12");
    repeat_step(TOUT - WAKE, 1, 0, "R12");
    repeat_step(4, 1, 1, "R12");
    repeat_step(1, 0, 1, "R12");
    repeat_step(WAKE - 1, 1, 1, "R12");
    repeat_step(1, 1, 0, "R12");

    step(1, 1, 1, 1, 0, 1, 2'd0, 0, 1, "R2");
    step(0, 0, 1, 1, 0, 0, 2'd1, 0, 1, "R3");
    step(0, 0, 1, 1, 0, 0, 2'd3, 0, 1, "R4");
    step(1, 0, 1, 0, 0, 1, 2'd0, 0, 1, "R2");
    step(0, 0, 0, 1, 0, 0, 2'd1, 0, 1, "R3");
    step(0, 0, 0, 1, 0, 0, 2'd2, 0, 1, "R8");
    step(1, 0, 0, 0, 0, 0, 2'd0, 0, 1, "R2");

    repeat (3) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule